// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block decides which of eight DRAM rows a physical address falls in. Software programs one 8-bit cumulative boundary per row: the value for row i is the running total of memory in rows 0 up to i, counted in 8 MB steps. The row whose span holds the top address bits is selected. A row whose boundary repeats the one below it is empty and takes up no address space, so the populated rows pack together from address zero.

Besides the one-hot row select, the block reports the selected row's page-size code and its bank count, both taken from per-row configuration fields. It also reports the address offset from the row's base and the page number within the row, which is that offset shifted right by the page size. An address that no row covers raises a miss flag instead. Each decode is launched with an address-valid strobe, and the result is held in registers one cycle later. Command generation and DRAM timing belong to other blocks.

Top module: `rowmap_decoder`

## Requirements
- R1: After reset every boundary, the page-size register and the bank register are zero and all outputs are zero; a decode issued right after reset reports a miss.
- R2: A write with cfgWrEn high loads cfgData[7:0] into boundary i when cfgSel = i (0..7), all 16 bits of cfgData into the page-size register when cfgSel = 8, and cfgData[7:0] into the bank register when cfgSel = 9. Selects 10 to 15 change nothing. A decode sampled in the same cycle as a write still uses the old register values.
- R3: With U = addr[31:23], row i is selected when U >= boundary(i-1) and U < boundary(i), taking boundary(-1) as 0. rowSel bit i is set for row i and never more than one bit is set.
- R4: A row whose boundary equals the boundary below it is never selected; its addresses fall to the next populated row.
- R5: When no row covers the address (for example when U >= boundary 7 and the boundaries rise monotonically), rowMiss is 1 and rowSel, rowPage, rowBanks, rowOffset and pageNum are all 0.
- R6: When boundaries that do not rise monotonically let several rows match, the lowest-numbered row is selected.
- R7: rowPage is bits [2i+1:2i] of the page-size register for the selected row i. The codes are 00 = 2 KB, 01 = 4 KB and 10 = 8 KB, and 11 is reserved.
- R8: rowBanks is bit i of the bank register for the selected row i. A 0 means 2 banks and a 1 means 4 banks.
- R9: rowOffset = addr - boundary(i-1) * 8 MB. pageNum = rowOffset >> (11 + code), and the reserved code 11 shifts by 13, the same as 8 KB.
- R10: A decode sampled with addrValid high appears on the outputs after that clock edge, and resValid is high for exactly that following cycle. While addrValid is low the decode outputs hold their values and resValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgSel | input | 4 | Register select: 0..7 boundary, 8 page size, 9 banks |
| cfgData | input | 16 | Write data |
| addrValid | input | 1 | Launch a decode of addr |
| addr | input | 32 | Physical byte address |
| rowSel | output | 8 | One-hot selected row |
| rowMiss | output | 1 | No row covers the address |
| rowPage | output | 2 | Page-size code of the selected row |
| rowBanks | output | 1 | Bank count of the selected row (0 = 2, 1 = 4) |
| rowOffset | output | 32 | Byte offset from the base of the selected row |
| pageNum | output | 32 | Page index within the selected row |
| resValid | output | 1 | Decode result updated this cycle |

## Verification
The case hardest to reach from the ports is rows that overlap. This only happens after boundaries have been programmed out of order, and then one address matches two rows at once. The bench programs such a set on purpose, sweeps every 8 MB unit across it, and adds random boundary writes during a long random run. It also issues boundary writes in the same cycle as a decode, to show that the decode in flight sees the old value and the next decode sees the new one.

// File: rtl/rowmap_pkg.sv
package rowmap_pkg;

  // Width of the configuration register select
  localparam int CFG_SEL_W = 4;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic                 ldBound;
    logic [CFG_SEL_W-1:0] boundIdx;
    logic                 ldPage;
    logic                 ldBank;
    logic                 ldResult;
  } rowmap_strobe_t;

endpackage

// File: rtl/rowmap_ctrl.sv
module rowmap_ctrl
  import rowmap_pkg::*;
#(
  parameter int NUM_ROWS = 8
) (
  input  logic                 cfgWrEn,
  input  logic [CFG_SEL_W-1:0] cfgSel,
  input  logic                 addrValid,
  output rowmap_strobe_t       strobes
);

  localparam logic [CFG_SEL_W-1:0] PAGE_SEL = CFG_SEL_W'(NUM_ROWS);
  localparam logic [CFG_SEL_W-1:0] BANK_SEL = CFG_SEL_W'(NUM_ROWS + 1);

  always_comb begin
    strobes.ldBound  = cfgWrEn && (cfgSel < PAGE_SEL);
    strobes.boundIdx = cfgSel;
    strobes.ldPage   = cfgWrEn && (cfgSel == PAGE_SEL);
    strobes.ldBank   = cfgWrEn && (cfgSel == BANK_SEL);
    strobes.ldResult = addrValid;
  end

endmodule

// File: rtl/rowmap_dpath.sv
module rowmap_dpath
  import rowmap_pkg::*;
#(
  parameter int NUM_ROWS       = 8,
  parameter int ADDR_W         = 32,
  parameter int BOUND_W        = 8,
  parameter int UNIT_SHIFT     = 23,
  parameter int PAGE_W         = 2,
  parameter int MIN_PAGE_SHIFT = 11,
  parameter int CFG_W          = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rowmap_strobe_t       strobes,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_ROWS-1:0]  rowSel,
  output logic                 rowMiss,
  output logic [PAGE_W-1:0]    rowPage,
  output logic                 rowBanks,
  output logic [ADDR_W-1:0]    rowOffset,
  output logic [ADDR_W-1:0]    pageNum,
  output logic                 resValid
);

  localparam int UNIT_W     = ADDR_W - UNIT_SHIFT;
  localparam int CMP_W      = (UNIT_W > BOUND_W) ? UNIT_W : BOUND_W;
  localparam int PAGE_REG_W = PAGE_W * NUM_ROWS;
  localparam int SHIFT_W    = $clog2(ADDR_W);
  localparam logic [PAGE_W-1:0] PAGE_RSVD = '1;
  localparam logic [PAGE_W-1:0] PAGE_BIG  = PAGE_W'((1 << PAGE_W) - 2);

  // Configuration state
  logic [BOUND_W-1:0]    bound [NUM_ROWS];
  logic [PAGE_REG_W-1:0] pageReg;
  logic [NUM_ROWS-1:0]   bankReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_ROWS; k++) bound[k] <= '0;
      pageReg <= '0;
      bankReg <= '0;
    end else begin
      for (int k = 0; k < NUM_ROWS; k++)
        if (strobes.ldBound && strobes.boundIdx == CFG_SEL_W'(k))
          bound[k] <= cfgData[BOUND_W-1:0];
      if (strobes.ldPage) pageReg <= cfgData[PAGE_REG_W-1:0];
      if (strobes.ldBank) bankReg <= cfgData[NUM_ROWS-1:0];
    end
  end

  // Per-row range compare against cumulative boundaries
  logic [UNIT_W-1:0]   addrUnit;
  logic [BOUND_W-1:0]  lowerEdge [NUM_ROWS];
  logic [NUM_ROWS-1:0] hitVec;

  assign addrUnit = addr[ADDR_W-1:UNIT_SHIFT];

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    if (g == 0) begin : g_first
      assign lowerEdge[g] = '0;
    end else begin : g_rest
      assign lowerEdge[g] = bound[g-1];
    end
    assign hitVec[g] = (CMP_W'(addrUnit) >= CMP_W'(lowerEdge[g])) &&
                       (CMP_W'(addrUnit) <  CMP_W'(bound[g]));
  end

  // Lowest-numbered matching row wins
  logic [NUM_ROWS-1:0] firstHit;
  assign firstHit = hitVec & (~hitVec + NUM_ROWS'(1));

  logic [PAGE_W-1:0]  selCode;
  logic               selBank;
  logic [BOUND_W-1:0] selBase;
  logic [PAGE_W-1:0]  effCode;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [ADDR_W-1:0]  offsetNext;
  logic [ADDR_W-1:0]  pageNext;

  always_comb begin
    selCode = '0;
    selBank = 1'b0;
    selBase = '0;
    for (int k = 0; k < NUM_ROWS; k++) begin
      if (firstHit[k]) begin
        selCode = pageReg[k*PAGE_W +: PAGE_W];
        selBank = bankReg[k];
        selBase = lowerEdge[k];
      end
    end
    effCode    = (selCode == PAGE_RSVD) ? PAGE_BIG : selCode;
    shiftAmt   = SHIFT_W'(MIN_PAGE_SHIFT) + SHIFT_W'(effCode);
    offsetNext = addr - (ADDR_W'(selBase) << UNIT_SHIFT);
    pageNext   = offsetNext >> shiftAmt;
  end

  // Registered decode result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowSel    <= '0;
      rowMiss   <= 1'b0;
      rowPage   <= '0;
      rowBanks  <= 1'b0;
      rowOffset <= '0;
      pageNum   <= '0;
      resValid  <= 1'b0;
    end else begin
      resValid <= strobes.ldResult;
      if (strobes.ldResult) begin
        rowSel  <= firstHit;
        rowMiss <= ~|hitVec;
        if (|hitVec) begin
          rowPage   <= selCode;
          rowBanks  <= selBank;
          rowOffset <= offsetNext;
          pageNum   <= pageNext;
        end else begin
          rowPage   <= '0;
          rowBanks  <= 1'b0;
          rowOffset <= '0;
          pageNum   <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/rowmap_decoder.sv
module rowmap_decoder
  import rowmap_pkg::*;
#(
  parameter int NUM_ROWS       = 8,
  parameter int ADDR_W         = 32,
  parameter int BOUND_W        = 8,
  parameter int UNIT_SHIFT     = 23,
  parameter int PAGE_W         = 2,
  parameter int MIN_PAGE_SHIFT = 11,
  parameter int CFG_W          = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_SEL_W-1:0] cfgSel,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 addrValid,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_ROWS-1:0]  rowSel,
  output logic                 rowMiss,
  output logic [PAGE_W-1:0]    rowPage,
  output logic                 rowBanks,
  output logic [ADDR_W-1:0]    rowOffset,
  output logic [ADDR_W-1:0]    pageNum,
  output logic                 resValid
);

  rowmap_strobe_t strobes;

  rowmap_ctrl #(
    .NUM_ROWS(NUM_ROWS)
  ) u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .addrValid(addrValid),
    .strobes  (strobes)
  );

  rowmap_dpath #(
    .NUM_ROWS      (NUM_ROWS),
    .ADDR_W        (ADDR_W),
    .BOUND_W       (BOUND_W),
    .UNIT_SHIFT    (UNIT_SHIFT),
    .PAGE_W        (PAGE_W),
    .MIN_PAGE_SHIFT(MIN_PAGE_SHIFT),
    .CFG_W         (CFG_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgData  (cfgData),
    .addr     (addr),
    .rowSel   (rowSel),
    .rowMiss  (rowMiss),
    .rowPage  (rowPage),
    .rowBanks (rowBanks),
    .rowOffset(rowOffset),
    .pageNum  (pageNum),
    .resValid (resValid)
  );

endmodule

// File: rtl/rowmap_chk.sv
module rowmap_chk #(
  parameter int NUM_ROWS = 8,
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                addrValid,
  input logic [NUM_ROWS-1:0] rowSel,
  input logic                rowMiss,
  input logic [PAGE_W-1:0]   rowPage,
  input logic                rowBanks,
  input logic [ADDR_W-1:0]   rowOffset,
  input logic [ADDR_W-1:0]   pageNum,
  input logic                resValid
);

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel));

  // R5
  miss_xor_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (rowMiss != (|rowSel)));

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowMiss |-> (rowPage == '0 && !rowBanks && rowOffset == '0 && pageNum == '0));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> resValid);

  // R10
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !resValid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> ($stable(rowSel) && $stable(rowMiss) && $stable(rowOffset)));

endmodule

bind rowmap_decoder rowmap_chk #(
  .NUM_ROWS(NUM_ROWS),
  .ADDR_W  (ADDR_W),
  .PAGE_W  (PAGE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addrValid(addrValid),
  .rowSel   (rowSel),
  .rowMiss  (rowMiss),
  .rowPage  (rowPage),
  .rowBanks (rowBanks),
  .rowOffset(rowOffset),
  .pageNum  (pageNum),
  .resValid (resValid)
);

// File: tb/tb_rowmap_decoder.sv
`timescale 1ns/1ps
module tb_rowmap_decoder;

  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic [NR-1:0] rowSel;
  logic        rowMiss, rowBanks, resValid;
  logic [1:0]  rowPage;
  logic [31:0] rowOffset, pageNum;

  always #2 clk = ~clk;

  rowmap_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .addrValid(addrValid), .addr(addr), .rowSel(rowSel), .rowMiss(rowMiss),
    .rowPage(rowPage), .rowBanks(rowBanks), .rowOffset(rowOffset),
    .pageNum(pageNum), .resValid(resValid)
  );

  // Behavioural reference state
  int          mBound [NR];
  int unsigned mPage, mBank;
  logic [NR-1:0] eSel;
  logic        eMiss, eBank, eValid;
  logic [1:0]  ePage;
  logic [31:0] eOff, ePn;

  int    nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit    checking = 1'b0, done = 1'b0;

  task automatic modelDecode(input logic [31:0] a);
    int unit, found, lo, code, sh;
    unit  = int'(a >> 23);
    found = -1;
    lo    = 0;
    for (int r = 0; r < NR; r++) begin
      int below;
      below = (r == 0) ? 0 : mBound[r-1];
      if (found < 0 && unit >= below && unit < mBound[r]) begin
        found = r;
        lo    = below;
      end
    end
    if (found < 0) begin
      eSel = '0; eMiss = 1'b1; ePage = '0; eBank = 1'b0; eOff = '0; ePn = '0;
    end else begin
      eSel  = NR'(1) << found;
      eMiss = 1'b0;
      code  = int'((mPage >> (2 * found)) & 3);
      ePage = code[1:0];
      eBank = ((mBank >> found) & 1) != 0;
      eOff  = a - (32'(lo) * 32'h0080_0000);
      sh    = 11 + ((code == 3) ? 2 : code);
      ePn   = eOff >> sh;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NR; r++) mBound[r] = 0;
      mPage = 0; mBank = 0;
      eSel = '0; eMiss = 1'b0; ePage = '0; eBank = 1'b0; eOff = '0; ePn = '0; eValid = 1'b0;
    end else begin
      eValid = addrValid;
      if (addrValid) modelDecode(addr);
      if (cfgWrEn) begin
        if (cfgSel < 8) mBound[cfgSel] = int'(cfgData & 16'h00FF);
        else if (cfgSel == 8) mPage = cfgData;
        else if (cfgSel == 9) mBank = cfgData & 16'h00FF;
      end
    end
  end

  task automatic chk(input string field, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, field, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      chk("rowSel",    32'(rowSel),   32'(eSel));
      chk("rowMiss",   32'(rowMiss),  32'(eMiss));
      chk("rowPage",   32'(rowPage),  32'(ePage));
      chk("rowBanks",  32'(rowBanks), 32'(eBank));
      chk("rowOffset", rowOffset,     eOff);
      chk("pageNum",   pageNum,       ePn);
      chk("resValid",  32'(resValid), 32'(eValid));
    end
  end

  task automatic drive(input bit w, input int sel, input int data, input bit v, input logic [31:0] a);
    cfgWrEn   = w;
    cfgSel    = sel[3:0];
    cfgData   = data[15:0];
    addrValid = v;
    addr      = a;
    @(negedge clk);
    cfgWrEn   = 1'b0;
    addrValid = 1'b0;
  endtask

  function automatic logic [31:0] at(input int unit, input int low);
    return {unit[8:0], low[22:0]};
  endfunction

  task automatic setBounds(input int b0, input int b1, input int b2, input int b3,
                           input int b4, input int b5, input int b6, input int b7);
    int vals [NR];
    vals = '{b0, b1, b2, b3, b4, b5, b6, b7};
    for (int r = 0; r < NR; r++) drive(1'b1, r, vals[r], 1'b0, 32'h0);
  endtask

  task automatic sweep(input int fromU, input int toU, input int low);
    for (int u = fromU; u <= toU; u++) drive(1'b0, 0, 0, 1'b1, at(u, low));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    checking = 1'b1;
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, 0, 0, 1'b1, at(0, 0));          // R1: miss with all boundaries zero
    drive(1'b0, 0, 0, 1'b1, at(3, 123));

    curReq = "R2";
    setBounds(16, 16, 24, 32, 40, 40, 48, 56);
    drive(1'b1, 8, 16'h49E4, 1'b0, 0);
    drive(1'b1, 9, 16'h00A5, 1'b0, 0);
    for (int s = 10; s < 16; s++) drive(1'b1, s, 16'hFFFF, 1'b1, at(s * 5, s));
    sweep(0, 60, 16'h1234);                      // R2: ignored selects left state intact
    drive(1'b1, 7, 60, 1'b1, at(58, 0));         // R2: same-cycle write uses old boundary
    drive(1'b0, 0, 0, 1'b1, at(58, 0));          // R2: next decode sees new boundary
    drive(1'b1, 7, 56, 1'b0, 0);

    curReq = "R3";
    sweep(0, 60, 0);
    sweep(0, 60, 32'h7FFFFF);

    curReq = "R4";
    drive(1'b0, 0, 0, 1'b1, at(16, 0));          // row1 empty -> row2
    drive(1'b0, 0, 0, 1'b1, at(40, 5));          // row5 empty -> row6

    curReq = "R5";
    drive(1'b0, 0, 0, 1'b1, at(56, 0));
    drive(1'b0, 0, 0, 1'b1, at(200, 99));
    drive(1'b0, 0, 0, 1'b1, 32'hFFFF_FFFF);

    curReq = "R7";
    for (int r = 0; r < 4; r++) begin
      drive(1'b1, 8, 16'h55AA ^ (r * 16'h1357), 1'b0, 0);
      sweep(0, 56, 16'h0800);
    end
    drive(1'b1, 8, 16'h49E4, 1'b0, 0);

    curReq = "R8";
    drive(1'b1, 9, 16'h005A, 1'b0, 0);
    sweep(0, 56, 7);

    curReq = "R9";
    for (int k = 0; k < 200; k++) drive(1'b0, 0, 0, 1'b1, $urandom() & 32'h1FFF_FFFF);

    curReq = "R6";
    setBounds(10, 5, 20, 20, 30, 3, 30, 40);
    sweep(0, 42, 16'h4321);

    curReq = "R10";
    drive(1'b0, 0, 0, 1'b1, at(2, 0));
    for (int k = 0; k < 10; k++) drive(1'b0, 0, 0, 1'b0, $urandom());
    drive(1'b0, 0, 0, 1'b1, at(35, 1));
    drive(1'b0, 0, 0, 1'b0, at(1, 1));

    curReq = "R3";
    for (int k = 0; k < 3000; k++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick == 0)
        drive(1'b1, int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)),
              1'b1, at(int'($urandom_range(0, 80)), int'($urandom())));
      else
        drive(1'b0, 0, 0, pick > 2, at(int'($urandom_range(0, 80)), int'($urandom())));
    end

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule